// File: doc/BRIEF.md
# Preloaded-Operand Multiply-Accumulate Unit

This block is the multiply path of a 16-bit signal-processing datapath. One multiplier input sits in a coefficient register that is written only by its own load command; every later multiply reuses that value until the next load. The other input is chosen per multiply, either from the data bus or from an immediate word carried on the program bus. Each multiply strobe leaves a full-width signed product in a product register, so a new product can be produced on every clock.

The registered product then passes through a barrel shifter and reaches a 32-bit accumulator. The shifter can take either the whole 32-bit product or only its low 16 bits, sign-extended. It shifts left or right, and a right shift is arithmetic. The accumulator loads, adds or subtracts the shifted value, or holds. A sum that overflows wraps modulo 2^32.

Top module: `tmul_mac`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the coefficient register, `prod_o` and `acc_o` become zero. After reset, a multiply without a prior load gives a product of zero.
- R2: When `coef_ld_i` is high at an edge, the coefficient register takes `dbus_i`. That value is the first multiplier input for every later multiply until the next load.
- R3: The second multiplier input is `pbus_i` when `src_imm_i` is 1 and `dbus_i` when it is 0. The choice is made separately for each multiply.
- R4: When `mul_en_i` is high at an edge, `prod_o` becomes the 32-bit two's-complement product of the coefficient and the selected operand, both taken as signed 16-bit values. This works on consecutive cycles, giving one new product per clock.
- R5: When `mul_en_i` is low at an edge, `prod_o` keeps its value whatever the buses carry.
- R6: A load and a multiply in the same cycle use the coefficient held before the load. The new coefficient applies from the next multiply onward.
- R7: The shifter moves its operand by `sh_amt_i` (0 to 31) places. With `sh_left_i`=1 it shifts left and fills with zeros. With `sh_left_i`=0 it shifts right and fills with copies of the sign bit.
- R8: With `sh_half_i`=1 the shifter operand is `prod_o[15:0]` sign-extended to 32 bits. With `sh_half_i`=0 it is the whole of `prod_o`.
- R9: At each edge the accumulator acts on the shifted value according to `acc_op_i`: 0 holds, 1 loads, 2 adds it to `acc_o`, and 3 subtracts it from `acc_o`. Results wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| coef_ld_i | input | 1 | Load coefficient register from data bus |
| mul_en_i | input | 1 | Multiply strobe, updates product register |
| src_imm_i | input | 1 | Second operand: 1 program-bus immediate, 0 data bus |
| dbus_i | input | 16 | Data bus word |
| pbus_i | input | 16 | Program bus immediate word |
| sh_amt_i | input | 5 | Shift distance |
| sh_left_i | input | 1 | 1 shift left, 0 arithmetic shift right |
| sh_half_i | input | 1 | 1 shift sign-extended low half of product |
| acc_op_i | input | 2 | Accumulator action: 0 hold, 1 load, 2 add, 3 subtract |
| prod_o | output | 32 | Product register |
| acc_o | output | 32 | Accumulator register |

## Verification
The multiplier is tested with small positive operands, mixed signs, two negative operands and the most negative value squared. These cases separate a correct signed product from an unsigned one and from a truncated one. Both operand sources are driven with different words in the same cycle, which shows which bus actually feeds the multiplier. A run of back-to-back multiplies and a load issued together with a multiply show whether a new product appears every cycle and which coefficient each multiply uses. The shifter and accumulator are tested with a negative value shifted right, which separates arithmetic from logical shift. They are also tested with a product whose low half has its top bit set, which separates half mode from full mode, and with a sum that crosses 2^31 and 2^32, which confirms the result wraps.

// File: rtl/tmul_pkg.sv
// Shared types and widths for the preloaded-operand multiply-accumulate unit.
// Assumes 16-bit signed operands and a product twice as wide.
package tmul_pkg;
    localparam int OPW  = 16;
    localparam int PRW  = 2 * OPW;
    localparam int SHAW = $clog2(PRW);

    // Accumulator action codes; the encoding is visible on acc_op_i.
    typedef enum logic [1:0] {
        ACC_HOLD = 2'd0,
        ACC_LOAD = 2'd1,
        ACC_ADD  = 2'd2,
        ACC_SUB  = 2'd3
    } acc_op_e;
endpackage

// File: rtl/tmul_coef_reg.sv
// Coefficient register: holds the preloaded multiplier input.
// Assumes a load strobe that is sampled on the rising edge; synchronous active-low reset.
module tmul_coef_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the data-bus word on a load strobe; otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= '0;
        else if (ld_i) q_o <= d_i;
    end
endmodule

// File: rtl/tmul_mult.sv
// Signed multiplier with operand selection and a registered product.
// Assumes two's-complement operands; the product register updates only on en_i.
module tmul_mult #(
    parameter int W = 16,
    localparam int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          sel_imm_i,
    input  logic [W-1:0]  coef_i,
    input  logic [W-1:0]  dbus_i,
    input  logic [W-1:0]  pbus_i,
    output logic [PW-1:0] prod_o
);
    logic [W-1:0]  opnd;
    logic [PW-1:0] full;

    // Pick the second operand for this multiply.
    always_comb opnd = sel_imm_i ? pbus_i : dbus_i;

    // Form the sign-correct full-width product.
    always_comb full = PW'($signed(coef_i) * $signed(opnd));

    // Register the product when a multiply is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)    prod_o <= '0;
        else if (en_i) prod_o <= full;
    end
endmodule

// File: rtl/tmul_shifter.sv
// Logarithmic barrel shifter: left with zero fill or arithmetic right.
// Assumes the amount is below the word width; half mode uses the sign-extended low half.
module tmul_shifter #(
    parameter int W  = 32,
    localparam int AW = $clog2(W),
    localparam int HW = W / 2
) (
    input  logic [W-1:0]  d_i,
    input  logic [AW-1:0] amt_i,
    input  logic          left_i,
    input  logic          half_i,
    output logic [W-1:0]  q_o
);
    logic [W-1:0] stg [0:AW];

    // Choose full word or sign-extended lower half as the shift source.
    always_comb stg[0] = half_i ? {{(W-HW){d_i[HW-1]}}, d_i[HW-1:0]} : d_i;

    // One stage per amount bit, each moving by a power of two.
    for (genvar i = 0; i < AW; i++) begin : g_stage
        localparam int DIST = 1 << i;
        logic [W-1:0] shl;
        logic [W-1:0] shr;
        always_comb begin
            shl = stg[i] << DIST;
            shr = W'($signed(stg[i]) >>> DIST);
            stg[i+1] = amt_i[i] ? (left_i ? shl : shr) : stg[i];
        end
    end

    // Final stage drives the output.
    always_comb q_o = stg[AW];
endmodule

// File: rtl/tmul_acc.sv
// Accumulator: holds, loads, adds or subtracts the shifted product, wrapping.
// Assumes the action code of tmul_pkg::acc_op_e.
module tmul_acc
    import tmul_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    acc_op_e      op;
    logic [W-1:0] nxt;

    // Decode the action and form the next accumulator value.
    always_comb begin
        op = acc_op_e'(op_i);
        unique case (op)
            ACC_LOAD: nxt = d_i;
            ACC_ADD:  nxt = q_o + d_i;
            ACC_SUB:  nxt = q_o - d_i;
            default:  nxt = q_o;
        endcase
    end

    // Commit the next value each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= '0;
        else        q_o <= nxt;
    end
endmodule

// File: rtl/tmul_mac.sv
// Top of the preloaded-operand multiply-accumulate unit.
// Coefficient register -> registered multiplier -> barrel shifter -> accumulator.
// Assumes a single clock and synchronous active-low reset.
module tmul_mac
    import tmul_pkg::*;
#(
    parameter int OW = OPW,
    localparam int PW = 2 * OW,
    localparam int AW = $clog2(PW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          coef_ld_i,
    input  logic          mul_en_i,
    input  logic          src_imm_i,
    input  logic [OW-1:0] dbus_i,
    input  logic [OW-1:0] pbus_i,
    input  logic [AW-1:0] sh_amt_i,
    input  logic          sh_left_i,
    input  logic          sh_half_i,
    input  logic [1:0]    acc_op_i,
    output logic [PW-1:0] prod_o,
    output logic [PW-1:0] acc_o
);
    logic [OW-1:0] coef;
    logic [PW-1:0] sh_val;

    tmul_coef_reg #(.W(OW)) i_coef (
        .clk(clk), .rst_n(rst_n), .ld_i(coef_ld_i), .d_i(dbus_i), .q_o(coef)
    );

    tmul_mult #(.W(OW)) i_mult (
        .clk(clk), .rst_n(rst_n), .en_i(mul_en_i), .sel_imm_i(src_imm_i),
        .coef_i(coef), .dbus_i(dbus_i), .pbus_i(pbus_i), .prod_o(prod_o)
    );

    tmul_shifter #(.W(PW)) i_shift (
        .d_i(prod_o), .amt_i(sh_amt_i), .left_i(sh_left_i),
        .half_i(sh_half_i), .q_o(sh_val)
    );

    tmul_acc #(.W(PW)) i_acc (
        .clk(clk), .rst_n(rst_n), .op_i(acc_op_i), .d_i(sh_val), .q_o(acc_o)
    );
endmodule

// File: rtl/tmul_mac_chk.sv
// Property checker for tmul_mac, attached with bind.
// Keeps its own shadow of the coefficient from the load strobe and data bus.
module tmul_mac_chk #(
    parameter int OW = 16,
    localparam int PW = 2 * OW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          coef_ld_i,
    input logic          mul_en_i,
    input logic          src_imm_i,
    input logic [OW-1:0] dbus_i,
    input logic [OW-1:0] pbus_i,
    input logic [1:0]    acc_op_i,
    input logic [PW-1:0] prod_o,
    input logic [PW-1:0] acc_o,
    input logic [PW-1:0] sh_val
);
    logic [OW-1:0] shadow_coef;
    logic [OW-1:0] opnd;

    // Track the coefficient from port activity alone.
    always_ff @(posedge clk) begin
        if (!rst_n)         shadow_coef <= '0;
        else if (coef_ld_i) shadow_coef <= dbus_i;
    end

    // Operand the port controls select.
    always_comb opnd = src_imm_i ? pbus_i : dbus_i;

    // R4 and R6: product uses the coefficient held before any same-cycle load.
    p_product_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mul_en_i |=> prod_o == PW'($signed($past(shadow_coef)) * $signed($past(opnd))));

    // R5: no strobe, no change.
    p_prod_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mul_en_i |=> $stable(prod_o));

    // R9: hold code keeps the accumulator.
    p_acc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_op_i == 2'd0 |=> $stable(acc_o));

    // R9: add code sums with wrap.
    p_acc_add_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_op_i == 2'd2 |=> acc_o == $past(acc_o) + $past(sh_val));

    // R9: subtract code with wrap.
    p_acc_sub_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_op_i == 2'd3 |=> acc_o == $past(acc_o) - $past(sh_val));
endmodule

bind tmul_mac tmul_mac_chk #(.OW(OW)) i_chk (
    .clk(clk), .rst_n(rst_n), .coef_ld_i(coef_ld_i), .mul_en_i(mul_en_i),
    .src_imm_i(src_imm_i), .dbus_i(dbus_i), .pbus_i(pbus_i), .acc_op_i(acc_op_i),
    .prod_o(prod_o), .acc_o(acc_o), .sh_val(sh_val)
);

// File: tb/test_tmul_mac.sv
// Directed bench for tmul_mac: one task per scenario, each checking its own results.
module test_tmul_mac;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        coef_ld_i, mul_en_i, src_imm_i, sh_left_i, sh_half_i;
    logic [15:0] dbus_i, pbus_i;
    logic [4:0]  sh_amt_i;
    logic [1:0]  acc_op_i;
    logic [31:0] prod_o, acc_o;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tmul_mac i_tmul_mac (
        .clk(clk), .rst_n(rst_n), .coef_ld_i(coef_ld_i), .mul_en_i(mul_en_i),
        .src_imm_i(src_imm_i), .dbus_i(dbus_i), .pbus_i(pbus_i),
        .sh_amt_i(sh_amt_i), .sh_left_i(sh_left_i), .sh_half_i(sh_half_i),
        .acc_op_i(acc_op_i), .prod_o(prod_o), .acc_o(acc_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        coef_ld_i = 0; mul_en_i = 0; src_imm_i = 0;
        dbus_i = 16'h0; pbus_i = 16'h0;
        sh_amt_i = 0; sh_left_i = 1; sh_half_i = 0; acc_op_i = 2'd0;
    endtask

    // One clock: inputs set after a falling edge take effect at the rising edge,
    // results are sampled at the following falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_coef(input logic [15:0] v);
        idle(); coef_ld_i = 1; dbus_i = v; tick(); idle();
    endtask

    task automatic mul(input logic imm, input logic [15:0] d, input logic [15:0] p);
        idle(); mul_en_i = 1; src_imm_i = imm; dbus_i = d; pbus_i = p; tick(); idle();
    endtask

    task automatic acc(input logic [1:0] op, input logic left, input logic [4:0] amt,
                       input logic half);
        idle(); acc_op_i = op; sh_left_i = left; sh_amt_i = amt; sh_half_i = half;
        tick(); idle();
    endtask

    task automatic t_reset();
        idle(); rst_n = 0; tick(); tick(); rst_n = 1;
        check("R1 prod after reset", prod_o, 32'h0);
        check("R1 acc after reset", acc_o, 32'h0);
        mul(0, 16'd1234, 16'd0);
        check("R1 coef zero after reset", prod_o, 32'h0);
    endtask

    task automatic t_sources();
        load_coef(16'd3);
        mul(0, 16'd5, 16'd77);
        check("R2 R3 data bus operand", prod_o, 32'd15);
        mul(1, 16'd100, 16'hFFFC);
        check("R3 immediate operand", prod_o, 32'hFFFF_FFF4);
    endtask

    task automatic t_signed();
        load_coef(16'hFFF9);               // -7
        mul(0, 16'hFFF7, 16'd0);           // -9
        check("R4 neg times neg", prod_o, 32'd63);
        load_coef(16'h8000);
        mul(1, 16'd0, 16'h8000);
        check("R4 most negative squared", prod_o, 32'h4000_0000);
    endtask

    task automatic t_back_to_back();
        // coefficient is -32768
        idle(); mul_en_i = 1; dbus_i = 16'd2; tick();
        check("R4 first of pair", prod_o, 32'hFFFF_0000);
        mul_en_i = 1; dbus_i = 16'd3; tick();
        check("R4 second of pair", prod_o, 32'hFFFE_8000);
        idle();
    endtask

    task automatic t_hold();
        idle(); dbus_i = 16'd9; pbus_i = 16'd9; src_imm_i = 1; tick(); tick(); idle();
        check("R5 product holds", prod_o, 32'hFFFE_8000);
    endtask

    task automatic t_same_cycle();
        idle(); coef_ld_i = 1; dbus_i = 16'd10; mul_en_i = 1; src_imm_i = 1;
        pbus_i = 16'd4; tick(); idle();
        check("R6 old coef used", prod_o, 32'hFFFE_0000);
        mul(1, 16'd0, 16'd4);
        check("R6 new coef next", prod_o, 32'd40);
    endtask

    task automatic t_acc_ops();
        acc(2'd1, 1, 5'd0, 0);
        check("R9 load", acc_o, 32'd40);
        acc(2'd2, 1, 5'd2, 0);
        check("R7 R9 add left shift", acc_o, 32'd200);
        acc(2'd3, 0, 5'd3, 0);
        check("R7 R9 sub right shift", acc_o, 32'd195);
        idle(); acc_op_i = 2'd0; sh_amt_i = 5'd7; tick(); idle();
        check("R9 hold", acc_o, 32'd195);
    endtask

    task automatic t_arith_right();
        mul(0, 16'hFF9C, 16'd0);           // 10 * -100 = -1000
        acc(2'd1, 0, 5'd4, 0);
        check("R7 arithmetic right", acc_o, 32'hFFFF_FFC1);
        acc(2'd1, 0, 5'd31, 0);
        check("R7 right by 31", acc_o, 32'hFFFF_FFFF);
    endtask

    task automatic t_half();
        mul(0, 16'h1000, 16'd0);           // 10 * 4096 = 0xA000
        acc(2'd1, 1, 5'd0, 1);
        check("R8 half sign-extended", acc_o, 32'hFFFF_A000);
        acc(2'd1, 1, 5'd0, 0);
        check("R8 full word", acc_o, 32'h0000_A000);
    endtask

    task automatic t_wrap();
        load_coef(16'h8000);
        mul(0, 16'h8000, 16'd0);
        acc(2'd1, 1, 5'd1, 0);
        check("R9 load 2^31", acc_o, 32'h8000_0000);
        acc(2'd2, 1, 5'd1, 0);
        check("R9 add wraps", acc_o, 32'h0000_0000);
        acc(2'd3, 1, 5'd0, 0);
        check("R9 sub wraps", acc_o, 32'hC000_0000);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(); rst_n = 0;
        tick();
        t_reset();
        t_sources();
        t_signed();
        t_back_to_back();
        t_hold();
        t_same_cycle();
        t_acc_ops();
        t_arith_right();
        t_half();
        t_wrap();
        t_reset();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule